// File: doc/BRIEF.md
# Inter-Processor Interrupt Doorbell

This block lets one processor raise an interrupt on another by writing a memory-mapped register. The sending side writes ones into a request register to post requests. The receiving side masks them with its own enable bits and sees a single level interrupt. After it has serviced the work, it clears the requests through an acknowledge register. Two copies, one for each direction, give notification both ways between a pair of processors.

Access is through an AXI4-Lite slave with valid/ready handshakes on all five channels. A write is taken in one cycle only when the address and the data are both valid and no earlier write response is still waiting. The response is then held until the master takes it with `s_bready`. A read is taken when `s_arready` is high, which it is whenever no read data is waiting. The returned data and its valid are then held steady until `s_rready`. Nothing is queued, so a master that holds `s_bready` or `s_rready` low stalls further traffic of that kind. The interrupt output is derived directly from the register state, so it changes in the cycle after the write handshake that caused the change.

Top module: `doorbell_top`

## Requirements
- R1: After reset, every register reads as zero, `irq_o` is low, and `s_bvalid` and `s_rvalid` are low.
- R2: A write to word offset 0x00 (request register) sets each request bit written as 1 and leaves bits written as 0 unchanged. A read of 0x00 returns the request bits in the low NUM_REQ positions.
- R3: Offset 0x04 reads the bitwise AND of the request and enable bits and is read-only: writes to it change no state.
- R4: Offset 0x08 holds the enable bits. A write replaces the enabled bytes, and a read returns them.
- R5: A write to offset 0x0C clears each request bit written as 1. Reads of 0x0C return zero.
- R6: Bit 0 of offset 0x1C is the master enable. It is writable and readable, and the other bits of 0x1C read as zero.
- R7: `irq_o` is high exactly when the master enable is set and at least one request bit is both set and enabled.
- R8: Every write and read response is OKAY (2'b00). Reads of unmapped offsets, including any address at or above 0x20, return zero, and writes to them change no state.
- R9: `s_awready` and `s_wready` are high only when both `s_awvalid` and `s_wvalid` are high and no write response is outstanding. `s_bvalid` stays high until it is taken with `s_bready`.
- R10: Once `s_rvalid` rises, it and `s_rdata` stay unchanged until `s_rready` is high, and `s_arready` is low throughout.
- R11: Write strobes act per byte: bits in a byte whose `s_wstrb` bit is 0 are not written, so they are neither set, cleared nor replaced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_awaddr | input | ADDR_W | Write address (byte address) |
| s_awvalid | input | 1 | Write address valid |
| s_awready | output | 1 | Write address ready |
| s_wdata | input | DATA_W | Write data |
| s_wstrb | input | DATA_W/8 | Write byte strobes |
| s_wvalid | input | 1 | Write data valid |
| s_wready | output | 1 | Write data ready |
| s_bresp | output | 2 | Write response, always OKAY |
| s_bvalid | output | 1 | Write response valid |
| s_bready | input | 1 | Write response ready |
| s_araddr | input | ADDR_W | Read address (byte address) |
| s_arvalid | input | 1 | Read address valid |
| s_arready | output | 1 | Read address ready |
| s_rdata | output | DATA_W | Read data |
| s_rresp | output | 2 | Read response, always OKAY |
| s_rvalid | output | 1 | Read data valid |
| s_rready | input | 1 | Read data ready |
| irq_o | output | 1 | Level interrupt toward the receiving processor |

## Verification
The assertions check, on every cycle, the handshake rules: responses are held under back-pressure, read data stays stable, no new read is taken while one is waiting, the write ready needs both channels, and responses are OKAY. They also check that the interrupt never rises without the master enable, and that the request bits change only in the cycle after an accepted write. Only the bench's scenarios can show the register semantics. These are set-only and clear-only writes, the read-only pending view, per-byte strobes, the zero reads of the acknowledge and unmapped offsets, and the exact interrupt level that follows each sequence of writes.

// File: rtl/db_pkg.sv
package db_pkg;

  // Word index of each register (byte offset / 4); the receiver's driver
  // decodes these positions, so they are fixed.
  typedef enum logic [2:0] {
    IDX_REQ    = 3'd0,
    IDX_PEND   = 3'd1,
    IDX_ENABLE = 3'd2,
    IDX_ACK    = 3'd3,
    IDX_MASTER = 3'd7
  } db_idx_e;

  // Bits of the byte address that select a word inside the mapped window
  localparam int unsigned WIN_LSB = 2;
  localparam int unsigned WIN_MSB = 4;
  localparam int unsigned WIN_BITS = WIN_MSB + 1;

  localparam logic [1:0] RESP_OKAY = 2'b00;

endpackage

// File: rtl/db_wr_port.sv
module db_wr_port #(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned DATA_W = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [ADDR_W-1:0]     awaddr,
  input  logic                  awvalid,
  output logic                  awready,
  input  logic [DATA_W-1:0]     wdata,
  input  logic [DATA_W/8-1:0]   wstrb,
  input  logic                  wvalid,
  output logic                  wready,
  output logic [1:0]            bresp,
  output logic                  bvalid,
  input  logic                  bready,
  output logic                  wr_fire,
  output logic [ADDR_W-1:0]     wr_addr,
  output logic [DATA_W-1:0]     wr_data,
  output logic [DATA_W-1:0]     wr_bmask
);
  import db_pkg::*;

  localparam int unsigned NBYTES = DATA_W / 8;

  logic bvalid_q;
  logic take;

  // Address and data are taken together, and only with the response slot free
  assign take    = awvalid && wvalid && !bvalid_q;
  assign awready = take;
  assign wready  = take;

  assign wr_fire = take;
  assign wr_addr = awaddr;
  assign wr_data = wdata;

  for (genvar b = 0; b < NBYTES; b++) begin : g_bytemask
    assign wr_bmask[8*b +: 8] = {8{wstrb[b]}};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bvalid_q <= 1'b0;
    end else if (take) begin
      bvalid_q <= 1'b1;
    end else if (bready) begin
      bvalid_q <= 1'b0;
    end
  end

  assign bvalid = bvalid_q;
  assign bresp  = RESP_OKAY;

endmodule

// File: rtl/db_rd_port.sv
module db_rd_port #(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] araddr,
  input  logic              arvalid,
  output logic              arready,
  output logic [DATA_W-1:0] rdata,
  output logic [1:0]        rresp,
  output logic              rvalid,
  input  logic              rready,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic [DATA_W-1:0] rd_value
);
  import db_pkg::*;

  logic              rvalid_q;
  logic [DATA_W-1:0] rdata_q;
  logic              take;

  assign arready = !rvalid_q;
  assign take    = arvalid && !rvalid_q;
  assign rd_addr = araddr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rvalid_q <= 1'b0;
      rdata_q  <= '0;
    end else if (take) begin
      rvalid_q <= 1'b1;
      rdata_q  <= rd_value;
    end else if (rready) begin
      rvalid_q <= 1'b0;
    end
  end

  assign rvalid = rvalid_q;
  assign rdata  = rdata_q;
  assign rresp  = RESP_OKAY;

endmodule

// File: rtl/db_regs.sv
module db_regs #(
  parameter int unsigned ADDR_W  = 12,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned NUM_REQ = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_fire,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic [DATA_W-1:0]  wr_data,
  input  logic [DATA_W-1:0]  wr_bmask,
  input  logic [ADDR_W-1:0]  rd_addr,
  output logic [DATA_W-1:0]  rd_value,
  output logic [NUM_REQ-1:0] status_q,
  output logic [NUM_REQ-1:0] enable_q,
  output logic               master_q,
  output logic               irq_o
);
  import db_pkg::*;

  logic              wr_hit;
  db_idx_e           wr_idx;
  logic [DATA_W-1:0] eff;
  logic [NUM_REQ-1:0] set_v, clr_v, bm_req, pending;
  logic              rd_hit;
  db_idx_e           rd_idx;

  always_comb begin
    wr_hit = (wr_addr >> WIN_BITS) == '0;
    wr_idx = db_idx_e'(wr_addr[WIN_MSB:WIN_LSB]);
    eff    = wr_data & wr_bmask;
    bm_req = wr_bmask[NUM_REQ-1:0];
    set_v  = '0;
    clr_v  = '0;
    if (wr_fire && wr_hit && wr_idx == IDX_REQ) set_v = eff[NUM_REQ-1:0];
    if (wr_fire && wr_hit && wr_idx == IDX_ACK) clr_v = eff[NUM_REQ-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      status_q <= '0;
      enable_q <= '0;
      master_q <= 1'b0;
    end else begin
      // a set posted with a clear of the same bit keeps the bit set
      status_q <= (status_q & ~clr_v) | set_v;
      if (wr_fire && wr_hit && wr_idx == IDX_ENABLE)
        enable_q <= (enable_q & ~bm_req) | eff[NUM_REQ-1:0];
      if (wr_fire && wr_hit && wr_idx == IDX_MASTER && wr_bmask[0])
        master_q <= wr_data[0];
    end
  end

  assign pending = status_q & enable_q;
  assign irq_o   = master_q && (|pending);

  always_comb begin
    rd_hit   = (rd_addr >> WIN_BITS) == '0;
    rd_idx   = db_idx_e'(rd_addr[WIN_MSB:WIN_LSB]);
    rd_value = '0;
    if (rd_hit) begin
      case (rd_idx)
        IDX_REQ:    rd_value = DATA_W'(status_q);
        IDX_PEND:   rd_value = DATA_W'(pending);
        IDX_ENABLE: rd_value = DATA_W'(enable_q);
        IDX_MASTER: rd_value = DATA_W'(master_q);
        default:    rd_value = '0;
      endcase
    end
  end

endmodule

// File: rtl/doorbell_top.sv
module doorbell_top #(
  parameter int unsigned ADDR_W  = 12,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned NUM_REQ = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ADDR_W-1:0]    s_awaddr,
  input  logic                 s_awvalid,
  output logic                 s_awready,
  input  logic [DATA_W-1:0]    s_wdata,
  input  logic [DATA_W/8-1:0]  s_wstrb,
  input  logic                 s_wvalid,
  output logic                 s_wready,
  output logic [1:0]           s_bresp,
  output logic                 s_bvalid,
  input  logic                 s_bready,
  input  logic [ADDR_W-1:0]    s_araddr,
  input  logic                 s_arvalid,
  output logic                 s_arready,
  output logic [DATA_W-1:0]    s_rdata,
  output logic [1:0]           s_rresp,
  output logic                 s_rvalid,
  input  logic                 s_rready,
  output logic                 irq_o
);

  logic               wr_fire;
  logic [ADDR_W-1:0]  wr_addr, rd_addr;
  logic [DATA_W-1:0]  wr_data, wr_bmask, rd_value;
  logic [NUM_REQ-1:0] status_q, enable_q;
  logic               master_q;

  db_wr_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_wr (
    .clk(clk), .rst_n(rst_n),
    .awaddr(s_awaddr), .awvalid(s_awvalid), .awready(s_awready),
    .wdata(s_wdata), .wstrb(s_wstrb), .wvalid(s_wvalid), .wready(s_wready),
    .bresp(s_bresp), .bvalid(s_bvalid), .bready(s_bready),
    .wr_fire(wr_fire), .wr_addr(wr_addr), .wr_data(wr_data), .wr_bmask(wr_bmask)
  );

  db_rd_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rd (
    .clk(clk), .rst_n(rst_n),
    .araddr(s_araddr), .arvalid(s_arvalid), .arready(s_arready),
    .rdata(s_rdata), .rresp(s_rresp), .rvalid(s_rvalid), .rready(s_rready),
    .rd_addr(rd_addr), .rd_value(rd_value)
  );

  db_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_REQ(NUM_REQ)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_fire(wr_fire), .wr_addr(wr_addr), .wr_data(wr_data), .wr_bmask(wr_bmask),
    .rd_addr(rd_addr), .rd_value(rd_value),
    .status_q(status_q), .enable_q(enable_q), .master_q(master_q),
    .irq_o(irq_o)
  );

endmodule

// File: rtl/db_chk.sv
module db_chk #(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned NUM_REQ = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               awready,
  input logic               wvalid,
  input logic               awvalid,
  input logic               bvalid,
  input logic               bready,
  input logic [1:0]         bresp,
  input logic               arready,
  input logic               rvalid,
  input logic               rready,
  input logic [DATA_W-1:0]  rdata,
  input logic [1:0]         rresp,
  input logic               irq,
  input logic               master_q,
  input logic               wr_fire,
  input logic [NUM_REQ-1:0] status_q
);

  AST_B_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    bvalid && !bready |=> bvalid);                                   // R9

  AST_AW_NEEDS_W: assert property (@(posedge clk) disable iff (!rst_n)
    awready |-> awvalid && wvalid);                                  // R9

  AST_R_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rvalid && !rready |=> rvalid && $stable(rdata));                 // R10

  AST_NO_AR_WHILE_R: assert property (@(posedge clk) disable iff (!rst_n)
    rvalid |-> !arready);                                            // R10

  AST_RESP_OKAY: assert property (@(posedge clk) disable iff (!rst_n)
    (bvalid |-> bresp == 2'b00) and (rvalid |-> rresp == 2'b00));    // R8

  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> master_q);                                               // R7

  AST_REQ_ONLY_BY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_fire |=> $stable(status_q));                                 // R2

endmodule

bind doorbell_top db_chk #(.DATA_W(DATA_W), .NUM_REQ(NUM_REQ)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .awready(s_awready), .wvalid(s_wvalid), .awvalid(s_awvalid),
  .bvalid(s_bvalid), .bready(s_bready), .bresp(s_bresp),
  .arready(s_arready), .rvalid(s_rvalid), .rready(s_rready),
  .rdata(s_rdata), .rresp(s_rresp),
  .irq(irq_o), .master_q(master_q), .wr_fire(wr_fire), .status_q(status_q)
);

// File: tb/tb_doorbell_top.sv
module tb_doorbell_top;

  localparam int unsigned ADDR_W  = 12;
  localparam int unsigned DATA_W  = 32;
  localparam int unsigned NUM_REQ = 8;
  localparam int unsigned NB      = DATA_W / 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;   // 50 MHz

  logic [ADDR_W-1:0] awaddr = '0, araddr = '0;
  logic awvalid = 0, wvalid = 0, bready = 0, arvalid = 0, rready = 0;
  logic [DATA_W-1:0] wdata = '0;
  logic [NB-1:0] wstrb = '0;
  logic awready, wready, bvalid, arready, rvalid, irq;
  logic [1:0] bresp, rresp;
  logic [DATA_W-1:0] rdata;

  doorbell_top #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_REQ(NUM_REQ)) dut (
    .clk(clk), .rst_n(rst_n),
    .s_awaddr(awaddr), .s_awvalid(awvalid), .s_awready(awready),
    .s_wdata(wdata), .s_wstrb(wstrb), .s_wvalid(wvalid), .s_wready(wready),
    .s_bresp(bresp), .s_bvalid(bvalid), .s_bready(bready),
    .s_araddr(araddr), .s_arvalid(arvalid), .s_arready(arready),
    .s_rdata(rdata), .s_rresp(rresp), .s_rvalid(rvalid), .s_rready(rready),
    .irq_o(irq)
  );

  int checks = 0;
  int failures = 0;
  bit done = 0;

  // model state
  logic [NUM_REQ-1:0] m_req = '0, m_en = '0;
  logic m_master = 1'b0;

  task automatic check(input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp,
                       input string tag);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  function automatic logic [DATA_W-1:0] exp_read(input logic [ADDR_W-1:0] a);
    if ((a >> 5) != 0) return '0;
    case (a[4:2])
      3'd0: return DATA_W'(m_req);
      3'd1: return DATA_W'(m_req & m_en);
      3'd2: return DATA_W'(m_en);
      3'd7: return DATA_W'(m_master);
      default: return '0;
    endcase
  endfunction

  function automatic logic exp_irq();
    return m_master && (|(m_req & m_en));
  endfunction

  task automatic model_write(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d,
                             input logic [NB-1:0] s);
    logic [DATA_W-1:0] bm;
    logic [NUM_REQ-1:0] e;
    for (int b = 0; b < NB; b++) bm[8*b +: 8] = {8{s[b]}};
    e = NUM_REQ'(d & bm);
    if ((a >> 5) == 0) begin
      case (a[4:2])
        3'd0: m_req = m_req | e;
        3'd2: m_en  = (m_en & ~NUM_REQ'(bm)) | e;
        3'd3: m_req = m_req & ~e;
        3'd7: if (s[0]) m_master = d[0];
        default: ;
      endcase
    end
  endtask

  task automatic axi_write(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d,
                           input logic [NB-1:0] s, input bit hold);
    @(negedge clk);
    awaddr = a; wdata = d; wstrb = s; awvalid = 1; wvalid = 1;
    #1;
    while (!awready) begin @(negedge clk); #1; end
    @(posedge clk);
    @(negedge clk);
    awvalid = 0; wvalid = 0;
    model_write(a, d, s);
    check(DATA_W'(bvalid), 1, "R9 bvalid after write");
    check(DATA_W'(bresp), 0, "R8 bresp OKAY");
    check(DATA_W'(irq), DATA_W'(exp_irq()), "R7 irq after write");
    if (hold) begin
      repeat (2) @(negedge clk);
      check(DATA_W'(bvalid), 1, "R9 bvalid held under back-pressure");
    end
    bready = 1;
    @(negedge clk);
    bready = 0;
    check(DATA_W'(bvalid), 0, "R9 bvalid dropped after bready");
  endtask

  task automatic axi_read(input logic [ADDR_W-1:0] a, input bit hold, input string tag);
    logic [DATA_W-1:0] first;
    @(negedge clk);
    araddr = a; arvalid = 1;
    #1;
    while (!arready) begin @(negedge clk); #1; end
    @(posedge clk);
    @(negedge clk);
    arvalid = 0;
    check(DATA_W'(rvalid), 1, "R10 rvalid after read");
    check(DATA_W'(rresp), 0, "R8 rresp OKAY");
    check(rdata, exp_read(a), tag);
    if (hold) begin
      first = rdata;
      repeat (2) @(negedge clk);
      check(DATA_W'(rvalid), 1, "R10 rvalid held");
      check(rdata, first, "R10 rdata stable");
      check(DATA_W'(arready), 0, "R10 arready low while data waits");
    end
    rready = 1;
    @(negedge clk);
    rready = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    check(DATA_W'(irq), 0, "R1 irq low after reset");
    check(DATA_W'(bvalid), 0, "R1 bvalid low after reset");
    check(DATA_W'(rvalid), 0, "R1 rvalid low after reset");
    axi_read(12'h000, 0, "R1 request reg zero");
    axi_read(12'h004, 0, "R1 pending reg zero");
    axi_read(12'h008, 0, "R1 enable reg zero");
    axi_read(12'h01C, 0, "R1 master reg zero");

    // R4 enable, R2 set, R3 pending, R7 gated by master
    axi_write(12'h008, 32'h1, 4'hF, 0);
    axi_read(12'h008, 0, "R4 enable readback");
    axi_write(12'h000, 32'h1, 4'hF, 0);
    axi_read(12'h004, 0, "R3 pending is 1");
    check(DATA_W'(irq), 0, "R7 irq low without master");
    axi_write(12'h01C, 32'hFFFF_FFFF, 4'hF, 1);
    axi_read(12'h01C, 0, "R6 master reads only bit0");
    check(DATA_W'(irq), 1, "R7 irq high with master");

    // R2 zero write no effect
    axi_write(12'h000, 32'h0, 4'hF, 0);
    axi_read(12'h000, 0, "R2 zero write keeps bit");
    // R3 read-only pending
    axi_write(12'h004, 32'hFF, 4'hF, 0);
    axi_read(12'h004, 0, "R3 pending unchanged by write");
    axi_read(12'h008, 0, "R3 enable unchanged by pending write");
    // R5 ack
    axi_read(12'h00C, 0, "R5 ack reads zero");
    axi_write(12'h000, 32'h6, 4'hF, 0);
    axi_write(12'h00C, 32'h1, 4'hF, 0);
    axi_read(12'h000, 0, "R5 ack cleared bit0 only");
    check(DATA_W'(irq), 0, "R7 irq low when requests not enabled");
    // R11 strobes
    axi_write(12'h000, 32'hFF, 4'h0, 0);
    axi_read(12'h000, 0, "R11 no strobe no set");
    axi_write(12'h008, 32'hFF, 4'h2, 0);
    axi_read(12'h008, 0, "R11 enable untouched by upper byte");
    axi_write(12'h01C, 32'h0, 4'hE, 0);
    axi_read(12'h01C, 0, "R11 master untouched without byte0");
    // R8 unmapped
    axi_write(12'h010, 32'hFF, 4'hF, 0);
    axi_write(12'h040, 32'hFF, 4'hF, 0);
    axi_write(12'h020, 32'hFF, 4'hF, 0);
    axi_read(12'h000, 0, "R8 unmapped writes no effect");
    axi_read(12'h040, 0, "R8 unmapped read zero");
    axi_read(12'h014, 1, "R8 unmapped read zero");
    // R9 address alone is not taken
    @(negedge clk);
    awaddr = 12'h000; wdata = 32'hFF; wstrb = 4'hF; awvalid = 1;
    #1;
    check(DATA_W'(awready), 0, "R9 awready low without wvalid");
    check(DATA_W'(wready), 0, "R9 wready low without wvalid");
    @(negedge clk);
    awvalid = 0;
    @(negedge clk);
    axi_read(12'h000, 1, "R9 lone address wrote nothing");

    // random phase
    for (int i = 0; i < 400; i++) begin
      logic [ADDR_W-1:0] a;
      logic [2:0] pick;
      pick = 3'($urandom_range(0, 7));
      case (pick)
        3'd0: a = 12'h000; 3'd1: a = 12'h004; 3'd2: a = 12'h008;
        3'd3: a = 12'h00C; 3'd4: a = 12'h01C; 3'd5: a = 12'h018;
        3'd6: a = 12'h000; default: a = 12'h100;
      endcase
      if ($urandom_range(0, 1) == 0)
        axi_write(a, $urandom(), 4'($urandom()), bit'($urandom_range(0, 1)));
      else
        axi_read(a, bit'($urandom_range(0, 1)), "R2 R3 R4 R5 R6 random readback");
      check(DATA_W'(irq), DATA_W'(exp_irq()), "R7 random irq level");
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule